// File: doc/BRIEF.md
# Chainable Up-Counting Timer with Trigger Start

This block is a 16-bit up-counter that can be started by a hardware event instead of by software. A slave controller watches one selectable trigger source. The source is either the rising edge of an external pin, sampled on the internal clock, or one of several internal trigger lines driven by neighbouring timers. In trigger mode, the first selected edge enables the counter. After that, the counter runs on every internal clock and wraps to zero at a programmable reload value.

A master controller can put the counter-enable state onto a registered trigger output. A second instance of the block watches that output on one of its internal trigger lines, so it starts as soon as the first timer starts. A master/slave delay bit holds back the first timer's count by one clock. As a result, both counters step on the same clock edge and show the same value on every cycle. The configuration fields are plain inputs. The block also takes a counter write, an update-generation pulse that zeroes the counter, and a trigger-flag clear.

Top module: `sync_timer`

## Requirements
- R1: With slave mode 3'b110 (trigger mode), a detected edge on the selected source sets `cnt_en` at the next clock edge. Any other slave mode never sets `cnt_en`.
- R2: Trigger select 3'b100 picks the external input. Its edge is a low sample followed by a high sample on two consecutive clocks, with two sampling registers in front. Selects 3'b000..3'b011 pick internal line 0..3. An internal line's edge is its current value high while its previous clock's value was low. Any other select value picks no source.
- R3: With master mode 3'b001, `trig_out` is registered and rises on the same clock edge as `cnt_en`. With any other master mode, `trig_out` stays low.
- R4: `trig_flag` is set on every trigger detected in trigger mode. It then stays set until `flag_clr` is high at a clock edge. A set in the same cycle wins over the clear.
- R5: With `cfg_ms_delay` high, the counter makes its first step one clock later than it would with the bit low. A slave timer chained through `trig_out` to its internal line 0 therefore holds the same count as the master on every cycle after a single external edge.
- R6: `upd_gen` high at a clock edge loads 0 into the counter. It takes priority over a counter write and over counting.
- R7: `cnt_wr` high at a clock edge loads `cnt_wdata` into the counter at any time, whether the counter is running or not.
- R8: A running counter that equals `cfg_reload` goes to 0 on the next step. Otherwise it adds one.
- R9: A trigger that arrives while `cnt_en` is already high leaves counting unchanged. It still sets `trig_flag`.
- R10: After a synchronous reset, `count`, `cnt_en`, `trig_flag` and `trig_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slave_mode | input | 3 | Slave mode; 3'b110 is trigger mode |
| cfg_trig_sel | input | 3 | Trigger source select |
| cfg_master_mode | input | 3 | Master mode; 3'b001 drives `trig_out` from the enable |
| cfg_ms_delay | input | 1 | Delays counting by one clock after enable |
| cfg_reload | input | CNT_W | Value after which the counter wraps to 0 |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Value loaded by `cnt_wr` |
| upd_gen | input | 1 | Update-generation pulse, zeroes the counter |
| flag_clr | input | 1 | Clears `trig_flag` |
| ext_in | input | 1 | External trigger input |
| itr_in | input | NUM_ITR | Internal trigger lines from other timers |
| trig_out | output | 1 | Registered trigger output |
| cnt_en | output | 1 | Counter-enable state |
| count | output | CNT_W | Counter value |
| trig_flag | output | 1 | Sticky trigger-detected flag |

## Verification
A bad enable or delay register shows up as a one-count skew between two chained timers. The skew appears on the first cycle after the start edge and persists from then on, so a per-cycle comparison of both counters exposes it at once. A broken edge detector or source select shows as a counter that never starts, or one that starts early, within three clocks of the stimulus. A fault in the flag shows on `trig_flag` at the first edge after a trigger or a clear. Faults in the wrap and load paths show on `count` at the step after the reload value or the write.

// File: rtl/sync_timer_pkg.sv
package sync_timer_pkg;
  localparam logic [2:0] SEL_EXT_EDGE = 3'b100;
  localparam logic [2:0] SLV_TRIGGER  = 3'b110;
  localparam logic [2:0] MST_ENABLE   = 3'b001;
  localparam int         MAX_ITR      = 4;
endpackage

// File: rtl/st_edge_detect.sv
module st_edge_detect #(
  parameter bit SYNC_IN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  generate
    if (SYNC_IN) begin : g_sampled
      logic smp_now, smp_prev;
      always_ff @(posedge clk) begin
        if (rst) begin
          smp_now  <= 1'b0;
          smp_prev <= 1'b0;
        end else begin
          smp_now  <= din;
          smp_prev <= smp_now;
        end
      end
      assign rise = smp_now & ~smp_prev;
    end else begin : g_direct
      logic last;
      always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= din;
      end
      assign rise = din & ~last;
    end
  endgenerate
endmodule

// File: rtl/st_trigger_ctrl.sv
module st_trigger_ctrl
  import sync_timer_pkg::*;
#(
  parameter int NUM_ITR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         slave_mode,
  input  logic [2:0]         trig_sel,
  input  logic [2:0]         master_mode,
  input  logic               ms_delay,
  input  logic               flag_clr,
  input  logic               ext_rise,
  input  logic [NUM_ITR-1:0] itr_rise,
  output logic               fire,
  output logic               run,
  output logic               cen,
  output logic               flag,
  output logic               tout
);
  localparam int USE_ITR = (NUM_ITR < MAX_ITR) ? NUM_ITR : MAX_ITR;

  logic sel_hit;
  logic cen_nxt;
  logic cen_late;

  always_comb begin
    sel_hit = 1'b0;
    if (trig_sel == SEL_EXT_EDGE) sel_hit = ext_rise;
    for (int k = 0; k < USE_ITR; k++) begin
      if (trig_sel == 3'(k)) sel_hit = itr_rise[k];
    end
  end

  assign fire    = sel_hit && (slave_mode == SLV_TRIGGER);
  assign cen_nxt = cen | fire;
  assign run     = ms_delay ? cen_late : cen;

  always_ff @(posedge clk) begin
    if (rst) begin
      cen      <= 1'b0;
      cen_late <= 1'b0;
      flag     <= 1'b0;
      tout     <= 1'b0;
    end else begin
      cen      <= cen_nxt;
      cen_late <= cen;
      tout     <= (master_mode == MST_ENABLE) && cen_nxt;
      if (fire)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/st_counter.sv
module st_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             zero,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)                  value <= '0;
    else if (zero)            value <= '0;
    else if (load)            value <= load_val;
    else if (run) begin
      if (value == reload)    value <= '0;
      else                    value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/sync_timer.sv
module sync_timer #(
  parameter int CNT_W   = 16,
  parameter int NUM_ITR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         cfg_slave_mode,
  input  logic [2:0]         cfg_trig_sel,
  input  logic [2:0]         cfg_master_mode,
  input  logic               cfg_ms_delay,
  input  logic [CNT_W-1:0]   cfg_reload,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic               upd_gen,
  input  logic               flag_clr,
  input  logic               ext_in,
  input  logic [NUM_ITR-1:0] itr_in,
  output logic               trig_out,
  output logic               cnt_en,
  output logic [CNT_W-1:0]   count,
  output logic               trig_flag
);
  logic               ext_rise;
  logic [NUM_ITR-1:0] itr_rise;
  logic               trig_fire;
  logic               cnt_run;

  st_edge_detect #(.SYNC_IN(1'b1)) u_ext_edge (
    .clk(clk), .rst(rst), .din(ext_in), .rise(ext_rise)
  );

  generate
    for (genvar g = 0; g < NUM_ITR; g++) begin : g_itr
      st_edge_detect #(.SYNC_IN(1'b0)) u_itr_edge (
        .clk(clk), .rst(rst), .din(itr_in[g]), .rise(itr_rise[g])
      );
    end
  endgenerate

  st_trigger_ctrl #(.NUM_ITR(NUM_ITR)) u_ctrl (
    .clk(clk), .rst(rst),
    .slave_mode(cfg_slave_mode), .trig_sel(cfg_trig_sel),
    .master_mode(cfg_master_mode), .ms_delay(cfg_ms_delay),
    .flag_clr(flag_clr), .ext_rise(ext_rise), .itr_rise(itr_rise),
    .fire(trig_fire), .run(cnt_run), .cen(cnt_en),
    .flag(trig_flag), .tout(trig_out)
  );

  st_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(cnt_run), .zero(upd_gen),
    .load(cnt_wr), .load_val(cnt_wdata), .reload(cfg_reload),
    .value(count)
  );
endmodule

// File: rtl/st_checker.sv
module st_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       master_mode,
  input logic             ms_delay,
  input logic [CNT_W-1:0] reload,
  input logic             wr,
  input logic [CNT_W-1:0] wdata,
  input logic             ug,
  input logic             clr,
  input logic             fire,
  input logic             run,
  input logic             cen,
  input logic             flag,
  input logic             tout,
  input logic [CNT_W-1:0] value
);
  a_r1_fire_enables: assert property (@(posedge clk) disable iff (rst)
    fire |=> cen);
  a_r3_tout_tracks_enable: assert property (@(posedge clk) disable iff (rst)
    (master_mode == 3'b001) |=> (tout == cen));
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  a_r4_flag_set: assert property (@(posedge clk) disable iff (rst)
    fire |=> flag);
  a_r5_delay_holds_first_step: assert property (@(posedge clk) disable iff (rst)
    (ms_delay && $rose(cen) && !wr && !ug) |=> $stable(value));
  a_r6_update_zeroes: assert property (@(posedge clk) disable iff (rst)
    ug |=> (value == '0));
  a_r7_write_loads: assert property (@(posedge clk) disable iff (rst)
    (wr && !ug) |=> (value == $past(wdata)));
  a_r8_wraps_at_reload: assert property (@(posedge clk) disable iff (rst)
    (run && value == reload && !wr && !ug) |=> (value == '0));
  a_r9_enable_stays: assert property (@(posedge clk) disable iff (rst)
    cen |=> cen);
endmodule

bind sync_timer st_checker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst(rst), .master_mode(cfg_master_mode), .ms_delay(cfg_ms_delay),
  .reload(cfg_reload), .wr(cnt_wr), .wdata(cnt_wdata), .ug(upd_gen),
  .clr(flag_clr), .fire(trig_fire), .run(cnt_run), .cen(cnt_en),
  .flag(trig_flag), .tout(trig_out), .value(count)
);

// File: tb/tb_sync_timer.sv
module tb_sync_timer;
  localparam int W = 16;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [2:0]   sm [2];
  logic [2:0]   sel[2];
  logic [2:0]   mm [2];
  logic         msd[2];
  logic [W-1:0] rl [2];
  logic         wr [2];
  logic [W-1:0] wd [2];
  logic         ug [2];
  logic         clr[2];
  logic         ext = 1'b0;

  logic         tout[2];
  logic         cen [2];
  logic [W-1:0] cnt [2];
  logic         flg [2];

  sync_timer #(.CNT_W(W), .NUM_ITR(NI)) dut (
    .clk(clk), .rst(rst), .cfg_slave_mode(sm[0]), .cfg_trig_sel(sel[0]),
    .cfg_master_mode(mm[0]), .cfg_ms_delay(msd[0]), .cfg_reload(rl[0]),
    .cnt_wr(wr[0]), .cnt_wdata(wd[0]), .upd_gen(ug[0]), .flag_clr(clr[0]),
    .ext_in(ext), .itr_in({NI{1'b0}}), .trig_out(tout[0]), .cnt_en(cen[0]),
    .count(cnt[0]), .trig_flag(flg[0])
  );

  sync_timer #(.CNT_W(W), .NUM_ITR(NI)) dut_slave (
    .clk(clk), .rst(rst), .cfg_slave_mode(sm[1]), .cfg_trig_sel(sel[1]),
    .cfg_master_mode(mm[1]), .cfg_ms_delay(msd[1]), .cfg_reload(rl[1]),
    .cnt_wr(wr[1]), .cnt_wdata(wd[1]), .upd_gen(ug[1]), .flag_clr(clr[1]),
    .ext_in(1'b0), .itr_in({{(NI-1){1'b0}}, tout[0]}), .trig_out(tout[1]),
    .cnt_en(cen[1]), .count(cnt[1]), .trig_flag(flg[1])
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit lockstep = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model, one entry per timer
  int m_e1, m_e2;
  int m_iq[2], m_en[2], m_enl[2], m_cnt[2], m_flag[2], m_to[2];

  always @(posedge clk) begin
    int hit, line, fire, go, nen, old_to0;
    if (rst) begin
      m_e1 = 0; m_e2 = 0;
      for (int i = 0; i < 2; i++) begin
        m_iq[i] = 0; m_en[i] = 0; m_enl[i] = 0; m_cnt[i] = 0; m_flag[i] = 0; m_to[i] = 0;
      end
    end else begin
      old_to0 = m_to[0];
      for (int i = 0; i < 2; i++) begin
        line = (i == 1) ? old_to0 : 0;
        hit = 0;
        if (sel[i] == 3'd4) hit = (m_e1 == 1 && m_e2 == 0) ? 1 : 0;
        else if (sel[i] == 3'd0) hit = (line == 1 && m_iq[i] == 0) ? 1 : 0;
        fire = (hit == 1 && sm[i] == 3'd6) ? 1 : 0;
        go = msd[i] ? m_enl[i] : m_en[i];
        nen = (m_en[i] == 1 || fire == 1) ? 1 : 0;
        if (ug[i]) m_cnt[i] = 0;
        else if (wr[i]) m_cnt[i] = int'(wd[i]);
        else if (go == 1) m_cnt[i] = (m_cnt[i] == int'(rl[i])) ? 0 : m_cnt[i] + 1;
        if (fire == 1) m_flag[i] = 1;
        else if (clr[i]) m_flag[i] = 0;
        m_to[i] = (mm[i] == 3'd1 && nen == 1) ? 1 : 0;
        m_enl[i] = m_en[i];
        m_en[i] = nen;
        m_iq[i] = line;
      end
      m_e2 = m_e1;
      m_e1 = int'(ext);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < 2; i++) begin
        chk("R1/R8", $sformatf("count[%0d]", i), int'(cnt[i]), m_cnt[i]);
        chk("R1", $sformatf("cnt_en[%0d]", i), int'(cen[i]), m_en[i]);
        chk("R4", $sformatf("trig_flag[%0d]", i), int'(flg[i]), m_flag[i]);
        chk("R3", $sformatf("trig_out[%0d]", i), int'(tout[i]), m_to[i]);
      end
      if (lockstep) chk("R5", "slave count equals master", int'(cnt[1]), int'(cnt[0]));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      sm[i] = 3'd6; mm[i] = 3'd0; rl[i] = 16'd12;
      wr[i] = 0; wd[i] = '0; ug[i] = 0; clr[i] = 0;
    end
    sel[0] = 3'd4; mm[0] = 3'd1; msd[0] = 1'b1;
    sel[1] = 3'd0; msd[1] = 1'b0;
    cyc(3);
    rst = 1'b0;
    // R10: reset state
    for (int i = 0; i < 2; i++) begin
      chk("R10", "count after reset", int'(cnt[i]), 0);
      chk("R10", "enable after reset", int'(cen[i]), 0);
      chk("R10", "flag after reset", int'(flg[i]), 0);
      chk("R10", "trig_out after reset", int'(tout[i]), 0);
    end
    ug[0] = 1; ug[1] = 1; cyc(1); ug[0] = 0; ug[1] = 0;
    cyc(4);
    // R5: single external edge starts both in lockstep
    lockstep = 1;
    ext = 1'b1;
    cyc(40);
    chk("R8", "counter stayed within reload", (int'(cnt[0]) <= 12) ? 1 : 0, 1);
    // R4: clear flags
    clr[0] = 1; clr[1] = 1; cyc(1); clr[0] = 0; clr[1] = 0;
    chk("R4", "flag cleared", int'(flg[0]), 0);
    cyc(2);
    // R9: retrigger while running
    ext = 1'b0; cyc(3); ext = 1'b1; cyc(4);
    chk("R9", "flag set by late trigger", int'(flg[0]), 1);
    chk("R9", "master still enabled", int'(cen[0]), 1);
    cyc(6);
    // R7: offset write into slave
    lockstep = 0;
    wr[1] = 1; wd[1] = 16'd5; cyc(1); wr[1] = 0;
    chk("R7", "slave loaded", int'(cnt[1]), 5);
    cyc(10);
    // R6: update pulse beats write
    ug[0] = 1; wr[0] = 1; wd[0] = 16'd77; cyc(1); ug[0] = 0; wr[0] = 0;
    chk("R6", "update zeroes master", int'(cnt[0]), 0);
    cyc(5);
    // R2: unused internal line selected, no start
    do_reset();
    ext = 1'b0; sel[0] = 3'd1;
    cyc(2); ext = 1'b1; cyc(8);
    chk("R2", "no start on idle line", int'(cen[0]), 0);
    chk("R2", "slave idle too", int'(cen[1]), 0);
    // R1: non-trigger slave mode ignores the edge
    do_reset();
    ext = 1'b0; sel[0] = 3'd4; sm[0] = 3'd0;
    cyc(2); ext = 1'b1; cyc(8);
    chk("R1", "no start outside trigger mode", int'(cen[0]), 0);
    chk("R1", "counter still zero", int'(cnt[0]), 0);
    // R5: without delay the slave lags one count
    do_reset();
    ext = 1'b0; sm[0] = 3'd6; msd[0] = 1'b0;
    cyc(2); ext = 1'b1; cyc(12);
    chk("R5", "one-count skew without delay", int'(cnt[0]) - int'(cnt[1]), 1);
    cyc(5);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule